// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends single bytes over a half-duplex smart card data line. The line is shared and open-drain, and an external pull-up holds it high. A byte arrives through a valid/ready handshake. The block then sends a character of ten bit slots: a low start bit, the eight data bits with the least significant bit first, and an even parity bit. Each slot lasts one elementary time unit (etu), which is a fixed number of clock cycles set by a parameter.

After the parity slot the block stops driving the line. The receiver may pull the line low to report a parity error, and the block samples the line once, 11 etu after the start edge. If it sees a low level there, it waits out the error signal and sends the same byte again. When the retry limit is used up, the block drops the byte and raises a one-cycle error flag. A character that gets through cleanly ends with a one-cycle done pulse.

The block only ever pulls the line low. The pad is wired so that `drive_low` enables a driver with a zero value. `line_in` is the level read back from the pad, and it passes through a synchroniser inside the block.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, `drive_low`, `done` and `err` are 0 and `in_ready` is 1.
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the cycle in which `done` or `err` is raised.
- R3: The start bit (line pulled low, `drive_low`=1) begins in the cycle after acceptance. It lasts exactly ETU_CYCLES cycles, which is slot 0.
- R4: Slots 1 to 8 carry data bits D0 to D7 in that order, one etu each. A 0 bit is sent as `drive_low`=1 and a 1 bit as `drive_low`=0.
- R5: Slot 9 carries even parity, so D0..D7 plus the parity bit hold an even number of ones.
- R6: In slots 10 and 11 the line is released (`drive_low`=0), and the line is never driven high.
- R7: If the line reads high when sampled 11 etu after the start edge, `done` pulses for one cycle at 12 etu after that start edge. `in_ready` returns to 1 in the same cycle.
- R8: If the line reads low at that sample, the same byte is sent again. Its start bit begins 14 etu after the previous start edge, and slots 12 and 13 stay released.
- R9: After RETRY_MAX retransmissions that all draw an error signal, `err` pulses for one cycle at 12 etu after the last start edge. The byte is then dropped and `done` stays 0.
- R10: `done` and `err` are never 1 together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| line_in | input | 1 | Level read back from the shared data line |
| drive_low | output | 1 | Enables the pad driver, which pulls the line low |
| done | output | 1 | One-cycle pulse: character delivered |
| err | output | 1 | One-cycle pulse: retries used up, byte dropped |

## Verification
The bench builds the block with ETU_CYCLES=8 and RETRY_MAX=2. A full character then takes 96 cycles, and a retry cycle takes 112. With these values a single run can reach the drop case and also the case where the last allowed retry succeeds. The bench's receiver model pulls the line low from 10.5 to 12.5 etu on the attempts it chooses to reject. The checks cover every bit slot at mid-etu, the released slots, and the exact cycle of `done` or `err`, for random bytes, random error counts, and the all-zero and all-one bytes.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RECOVER = 2'd3
  } tx_state_t;

  localparam int SLOT_W        = 4;
  localparam int FRAME_BITS    = 10;
  localparam int SLOT_PARITY   = 9;
  localparam int SLOT_SAMPLE   = 11;
  localparam int SLOT_HOLD_END = 11;
  localparam int SLOT_REC_END  = 13;

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_CYCLES = 372
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic first,
  output logic last
);
  localparam int CW = (ETU_CYCLES > 2) ? $clog2(ETU_CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(ETU_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign first = (cnt == '0);
  assign last  = (cnt == TOP);
endmodule

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) q[0] <= 1'b1;
          else     q[0] <= din;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) q[g] <= 1'b1;
          else     q[g] <= q[g-1];
        end
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sc_retry_ctr.sv
module sc_retry_ctr #(
  parameter int RETRY_MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int RW = $clog2(RETRY_MAX + 1) > 0 ? $clog2(RETRY_MAX + 1) : 1;
  localparam logic [RW-1:0] LIM = RW'(RETRY_MAX);

  logic [RW-1:0] n;

  always_ff @(posedge clk) begin
    if (rst || clr)             n <= '0;
    else if (inc && (n != LIM)) n <= n + 1'b1;
  end

  assign spent = (n == LIM);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int ETU_CYCLES  = 372,
  parameter int RETRY_MAX   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       line_in,
  output logic       drive_low,
  output logic       done,
  output logic       err
);
  import sc_tx_pkg::*;

  localparam logic [SLOT_W-1:0] S_PAR  = SLOT_W'(SLOT_PARITY);
  localparam logic [SLOT_W-1:0] S_SMP  = SLOT_W'(SLOT_SAMPLE);
  localparam logic [SLOT_W-1:0] S_HEND = SLOT_W'(SLOT_HOLD_END);
  localparam logic [SLOT_W-1:0] S_REND = SLOT_W'(SLOT_REC_END);

  tx_state_t               state;
  logic [SLOT_W-1:0]       slot;
  logic [FRAME_BITS-1:0]   frame;
  logic                    err_seen;
  logic                    tk_first, tk_last;
  logic                    line_s;
  logic                    spent;
  logic                    retry_inc;

  sc_etu_timer #(.ETU_CYCLES(ETU_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE),
    .first(tk_first), .last(tk_last)
  );

  sc_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(line_s)
  );

  assign retry_inc = (state == ST_RECOVER) && tk_last && (slot == S_REND);

  sc_retry_ctr #(.RETRY_MAX(RETRY_MAX)) i_retry (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE),
    .inc(retry_inc), .spent(spent)
  );

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      slot      <= '0;
      frame     <= '1;
      err_seen  <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          drive_low <= 1'b0;
          if (in_valid) begin
            frame     <= {even_par(in_data), in_data, 1'b0};
            slot      <= '0;
            drive_low <= 1'b1;
            state     <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tk_last) begin
            if (slot == S_PAR) begin
              slot      <= slot + 1'b1;
              drive_low <= 1'b0;
              state     <= ST_HOLD;
            end else begin
              slot      <= slot + 1'b1;
              drive_low <= ~frame[slot + 1'b1];
            end
          end
        end
        ST_HOLD: begin
          drive_low <= 1'b0;
          if (tk_first && (slot == S_SMP)) err_seen <= ~line_s;
          if (tk_last) begin
            if (slot == S_HEND) begin
              if (err_seen && spent) begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end else if (err_seen) begin
                slot  <= slot + 1'b1;
                state <= ST_RECOVER;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        ST_RECOVER: begin
          drive_low <= 1'b0;
          if (tk_last) begin
            if (slot == S_REND) begin
              slot      <= '0;
              drive_low <= 1'b1;
              state     <= ST_SEND;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic drive_low,
  input logic done,
  input logic err
);
  // R2 / R3: acceptance starts the start bit and makes the block busy
  p_accept_start_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (drive_low && !in_ready));

  // R6: while idle the line is never pulled
  p_idle_released_r6: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !drive_low);

  // R10: the two completion pulses never coincide
  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R10: single-cycle pulses
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R7 / R9: completion comes with ready again
  p_ready_on_finish_r7: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> in_ready);

  // R2: ready only rises together with a completion pulse
  p_ready_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> (done || err));
endmodule

bind sc_char_tx sc_char_tx_chk i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .drive_low(drive_low), .done(done), .err(err)
);

// File: tb/test_sc_char_tx.sv
module test_sc_char_tx;
  localparam int CLK_PERIOD = 10;
  localparam int ETU        = 8;
  localparam int RMAX       = 2;
  localparam int CYC_TRY    = 14 * ETU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, drive_low, done, err;
  logic       pull = 1'b0;
  logic       line_in;
  int         total = 0;
  int         bad = 0;

  assign line_in = ~(drive_low | pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_char_tx #(.ETU_CYCLES(ETU), .RETRY_MAX(RMAX), .SYNC_STAGES(2)) i_sc_char_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_in(line_in), .drive_low(drive_low),
    .done(done), .err(err)
  );

  // expected drive_low in a bit slot (0..9): pulled low for a 0 bit
  function automatic logic exp_drive(input logic [7:0] d, input int s);
    if (s == 0) return 1'b1;
    if (s <= 8) return ~d[s-1];
    return ~(^d);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] d, input int nerr);
    int n_att, fin;
    n_att = (nerr > RMAX) ? RMAX + 1 : nerr + 1;
    fin   = (n_att - 1) * CYC_TRY + 12 * ETU;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    chk("R2 ready before offer", in_ready, 1'b1);
    @(posedge clk);
    for (int c = 0; c <= fin; c++) begin
      int a, r, s;
      @(negedge clk);
      if (c == 0) in_valid = 1'b0;
      a = c / CYC_TRY;
      r = c % CYC_TRY;
      s = r / ETU;
      pull = (a < nerr) && (r >= 10*ETU + ETU/2) && (r < 12*ETU + ETU/2);
      if (r % ETU == ETU/2) begin
        if (s == 0)
          chk(a > 0 ? "R8 resend start" : "R3 start bit", drive_low, 1'b1);
        else if (s <= 8)
          chk(a > 0 ? "R8 resend data" : "R4 data bit", drive_low, exp_drive(d, s));
        else if (s == 9)
          chk("R5 parity", drive_low, exp_drive(d, 9));
        else if (s <= 11)
          chk("R6 released", drive_low, 1'b0);
        else
          chk("R8 recover released", drive_low, 1'b0);
      end
      if (c == ETU/2) chk("R2 busy", in_ready, 1'b0);
      if (c == ETU - 1) chk("R3 start length", drive_low, 1'b1);
      if (c == fin - 1) begin
        chk("R10 no early done", done, 1'b0);
        chk("R10 no early err", err, 1'b0);
      end
      if (c == fin) begin
        if (nerr > RMAX) begin
          chk("R9 err pulse", err, 1'b1);
          chk("R9 no done", done, 1'b0);
        end else begin
          chk("R7 done pulse", done, 1'b1);
          chk("R7 no err", err, 1'b0);
        end
        chk("R7 ready again", in_ready, 1'b1);
      end
    end
    pull = 1'b0;
    @(negedge clk);
    chk("R10 pulse one cycle", done | err, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 drive_low", drive_low, 1'b0);
    chk("R1 in_ready", in_ready, 1'b1);
    chk("R1 done", done, 1'b0);
    chk("R1 err", err, 1'b0);
    // directed corners
    send(8'h00, 0);
    send(8'hFF, 0);
    send(8'hA5, 1);
    send(8'h3C, RMAX);       // last permitted retry succeeds
    send(8'h81, RMAX + 1);   // drop
    send(8'h7E, 0);          // clean after a drop
    // random stimulus
    for (int i = 0; i < 24; i++) begin
      send(8'($urandom), int'($urandom % (RMAX + 2)));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule